// File: doc/BRIEF.md
# I2S Balanced Serial-Data Splitter

This block takes a standard I2S stream (bit clock, word select, serial data) carrying 16-bit two's-complement stereo samples. It re-emits each sample for a balanced pair of multibit DACs. Every channel gets two serial lines. The true line carries the sample and the negated line carries its exact arithmetic negation. The left and right pairs sit on separate lines and play out at the same time, so one DAC can take both polarities of one channel with no half-frame skew between channels.

The output words are LSB-justified. Each word ends one bit period before a per-channel latch strobe, and that strobe lands on the next frame boundary. The words received in one frame play out during the following frame.

The bit clock is the only clock. Output lines change on its falling edge. The true and negated lanes are four copies of one lane structure. Each lane ends in an XOR against a constant polarity (0 or 1), so the true and negated edges pass through matched logic.

Top module: `i2s_bal_split`

## Requirements
- R1: Word select and serial data are sampled on the rising edge of `clk`. `ws_i` low marks the left slot and high marks the right slot. A word's MSB is the bit sampled on the first rising edge after the one that first sees the new `ws_i` level, and the next 15 bits follow MSB first.
- R2: Only the first 16 bits of a slot are kept. Extra bits in a longer slot are ignored, as is the bit sampled on the word-select change edge. A captured word changes only on a rising edge that sees a word-select change.
- R3: With FRAME_BITS = 64, number the bit periods of a frame 0 to 63, where period 0 is the first period whose rising edge sees `ws_i` low after a high level. The left and right samples received in frame k appear on `l_true_o` and `r_true_o` MSB first during periods 48 to 63 of frame k+1. Bit 15 is in period 48 and bit 0 is in period 63.
- R4: `l_neg_o` and `r_neg_o` carry the two's-complement negation of the sample in the same periods, not the bitwise inverse. For example, 0x0001 gives 0xFFFF and 0x0000 gives 0x0000.
- R5: A sample of 0x8000 gives 0x7FFF on the negated line.
- R6: `l_lat_o` and `r_lat_o` are high for exactly one bit period, which is period 0 of frame k+2, right after the LSB. All four data lines are low outside the 16-bit window, including during the strobe.
- R7: Left and right play out at the same time on their own lines, with identical timing.
- R8: `rst` is a synchronous, active-high reset. After reset all data lines and strobes stay low until one complete left-then-right frame has been received. The partial frame in progress when reset is released is discarded. A reset in the middle of a stream returns the outputs to zero.
- R9: Output lines and strobes change only on the falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I2S bit clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_i | input | 1 | I2S word select (low = left) |
| sd_i | input | 1 | I2S serial data |
| l_true_o | output | 1 | Left sample, LSB-justified serial |
| l_neg_o | output | 1 | Negated left sample, LSB-justified serial |
| r_true_o | output | 1 | Right sample, LSB-justified serial |
| r_neg_o | output | 1 | Negated right sample, LSB-justified serial |
| l_lat_o | output | 1 | Left latch strobe |
| r_lat_o | output | 1 | Right latch strobe |

## Verification
The bench feeds sample words chosen to expose a negation that was built as plain inversion: 0x0001, 0x0000, 0xFFFF and 0x7FFF. Inversion would put all ones on the line for zero, and would be off by one everywhere else. The bench also feeds 0x8000, where a wrapping negation would send 0x8000 back out instead of 0x7FFF.

The unused tail of every slot and the bit on the word-select change edge are filled with random bits. A capture that ran past 16 bits, or that was misaligned by one, would show up as shifted or corrupted words. Every bit period is compared against a behavioural model, so a window one period early or late, or a strobe that lasts more than one period, fails on the bit where it diverges.

The bench releases reset and also reasserts it in the middle of a frame. This catches a design that would play out the partial first frame or keep old data across a reset.

// File: rtl/bal_split_pkg.sv
package bal_split_pkg;

  // Polarity selector for one output lane: the final XOR constant.
  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_NEG  = 1'b1
  } lane_pol_e;

  localparam int unsigned DEF_SAMPLE_W  = 16;
  localparam int unsigned DEF_FRAME_BITS = 64;
  localparam int unsigned NUM_CH        = 2;

endpackage

// File: rtl/bal_split_rx.sv
// Deserialises an I2S stream into one held word per channel and flags
// each complete left-then-right frame.
module bal_split_rx #(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic [W-1:0]        hold_l,
  output logic [W-1:0]        hold_r,
  output logic                frame_rdy
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          ws_q;
  logic          started;
  logic          left_ok;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sr;

  logic          ws_chg;
  logic          take;
  logic [W-1:0]  sr_nx;
  logic [CW-1:0] cnt_nx;
  logic          word_full;

  always_comb begin
    ws_chg    = ws_i ^ ws_q;
    take      = (cnt < CW'(W));
    sr_nx     = take ? {sr[W-2:0], sd_i} : sr;
    cnt_nx    = take ? cnt + CW'(1) : cnt;
    word_full = started && (cnt_nx == CW'(W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q      <= 1'b0;
      started   <= 1'b0;
      left_ok   <= 1'b0;
      cnt       <= CW'(W);
      sr        <= '0;
      hold_l    <= '0;
      hold_r    <= '0;
      frame_rdy <= 1'b0;
    end else begin
      ws_q      <= ws_i;
      frame_rdy <= 1'b0;
      if (ws_chg) begin
        started <= 1'b1;
        cnt     <= '0;
        sr      <= '0;
        if (!ws_q) begin
          // left slot just closed
          if (word_full) hold_l <= sr_nx;
          left_ok <= word_full;
        end else begin
          // right slot just closed: frame complete when both words are
          if (word_full) hold_r <= sr_nx;
          frame_rdy <= word_full && left_ok;
          left_ok   <= 1'b0;
        end
      end else begin
        sr  <= sr_nx;
        cnt <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/bal_split_sched.sv
// Bit-position counter for the output frame: opens the 16-bit window that
// ends one period before the frame boundary, and marks the strobe slot.
module bal_split_sched #(
  parameter int unsigned W     = 16,
  parameter int unsigned FRAME = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_rdy,
  output logic win,
  output logic strb
);
  localparam int unsigned PW     = $clog2(FRAME + 1);
  localparam int unsigned WIN_LO = FRAME - W - 1;
  localparam int unsigned WIN_HI = FRAME - 2;

  logic [PW-1:0] pos;

  // frame_rdy arrives one cycle after the boundary edge, hence the reload to 1.
  always_ff @(posedge clk) begin
    if (rst)                    pos <= PW'(FRAME);
    else if (frame_rdy)         pos <= PW'(1);
    else if (pos != PW'(FRAME)) pos <= pos + PW'(1);
  end

  always_comb begin
    win  = (pos >= PW'(WIN_LO)) && (pos <= PW'(WIN_HI));
    strb = (pos == PW'(FRAME - 1));
  end

endmodule

// File: rtl/bal_split_lane.sv
// One serial output lane. All four lanes share this structure; only the
// constant in the final XOR differs, so true and negated edges match.
module bal_split_lane
  import bal_split_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter lane_pol_e   POL = POL_TRUE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         win,
  output logic         dout
);
  logic [W-1:0] sr;
  logic         bit_x;

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= word;
    else if (win)  sr <= {sr[W-2:0], 1'b0};
  end

  always_comb bit_x = win & (sr[W-1] ^ logic'(POL));

  always_ff @(negedge clk) begin
    dout <= bit_x;
  end

endmodule

// File: rtl/i2s_bal_split.sv
module i2s_bal_split
  import bal_split_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = DEF_SAMPLE_W,
  parameter int unsigned FRAME_BITS = DEF_FRAME_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic ws_i,
  input  logic sd_i,
  output logic l_true_o,
  output logic l_neg_o,
  output logic r_true_o,
  output logic r_neg_o,
  output logic l_lat_o,
  output logic r_lat_o
);
  localparam int unsigned NLANE = 2 * NUM_CH;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] hold_l;
  logic [SAMPLE_W-1:0] hold_r;
  logic                frame_rdy;
  logic                win;
  logic                strb;

  logic [NUM_CH-1:0][SAMPLE_W-1:0] ch_word;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] ch_pre;
  logic [NLANE-1:0]                lane_out;
  logic [NUM_CH-1:0]               lat_q;

  bal_split_rx #(.W(SAMPLE_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .ws_i      (ws_i),
    .sd_i      (sd_i),
    .hold_l    (hold_l),
    .hold_r    (hold_r),
    .frame_rdy (frame_rdy)
  );

  bal_split_sched #(.W(SAMPLE_W), .FRAME(FRAME_BITS)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .frame_rdy (frame_rdy),
    .win       (win),
    .strb      (strb)
  );

  assign ch_word[0] = hold_l;
  assign ch_word[1] = hold_r;

  // -x = ~(x - 1); the negated lane serialises x - 1 and inverts in its XOR.
  // The most negative value keeps itself so that the lane yields the
  // saturated positive maximum.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      if (ch_word[c] == MOST_NEG) ch_pre[c] = ch_word[c];
      else                        ch_pre[c] = ch_word[c] - SAMPLE_W'(1);
    end

    for (genvar p = 0; p < 2; p++) begin : g_pol
      localparam lane_pol_e LPOL = (p == 0) ? POL_TRUE : POL_NEG;
      bal_split_lane #(.W(SAMPLE_W), .POL(LPOL)) u_lane (
        .clk  (clk),
        .rst  (rst),
        .load (frame_rdy),
        .word ((p == 0) ? ch_word[c] : ch_pre[c]),
        .win  (win),
        .dout (lane_out[2*c + p])
      );
    end

    always_ff @(negedge clk) begin
      lat_q[c] <= strb;
    end
  end

  assign l_true_o = lane_out[0];
  assign l_neg_o  = lane_out[1];
  assign r_true_o = lane_out[2];
  assign r_neg_o  = lane_out[3];
  assign l_lat_o  = lat_q[0];
  assign r_lat_o  = lat_q[1];

endmodule

// File: rtl/i2s_bal_split_chk.sv
module i2s_bal_split_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ws_i,
  input logic [W-1:0] hold_l,
  input logic [W-1:0] hold_r,
  input logic         l_true_o,
  input logic         l_neg_o,
  input logic         r_true_o,
  input logic         r_neg_o,
  input logic         l_lat_o,
  input logic         r_lat_o
);

  // R2: captured words only move on a word-select change
  assert_hold_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (ws_i == $past(ws_i))) |=> ($stable(hold_l) && $stable(hold_r)));

  // R6: a strobe lasts one bit period
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    (l_lat_o || r_lat_o) |=> (!l_lat_o && !r_lat_o));

  // R6: data lines are quiet while a strobe is high
  assert_strobe_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (l_lat_o || r_lat_o) |-> !(l_true_o || l_neg_o || r_true_o || r_neg_o));

  // R8: outputs cleared right after reset
  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(l_true_o || l_neg_o || r_true_o || r_neg_o || l_lat_o || r_lat_o));

endmodule

bind i2s_bal_split i2s_bal_split_chk #(.W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ws_i     (ws_i),
  .hold_l   (hold_l),
  .hold_r   (hold_r),
  .l_true_o (l_true_o),
  .l_neg_o  (l_neg_o),
  .r_true_o (r_true_o),
  .r_neg_o  (r_neg_o),
  .l_lat_o  (l_lat_o),
  .r_lat_o  (r_lat_o)
);

// File: tb/i2s_bal_split_tb.sv
module i2s_bal_split_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int FB = 64;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ws  = 1'b0;
  logic sd  = 1'b0;
  logic lt, ln, rt, rn, ll, rl;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] lw [NF];
  logic [W-1:0] rw [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_bal_split #(.SAMPLE_W(W), .FRAME_BITS(FB)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .ws_i     (ws),
    .sd_i     (sd),
    .l_true_o (lt),
    .l_neg_o  (ln),
    .r_true_o (rt),
    .r_neg_o  (rn),
    .l_lat_o  (ll),
    .r_lat_o  (rl)
  );

  function automatic logic [W-1:0] neg_sat(logic [W-1:0] x);
    if (x == 16'h8000) return 16'h7FFF;
    return 16'(~x + 16'd1);
  endfunction

  task automatic check(string tg, logic [1:0] act, logic [1:0] exp, int g);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s period=%0d act=%b exp=%b", tg, g, act, exp);
    end
  endtask

  // R8: reset asserted from the middle of anything
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ws = 1'b0; sd = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    check("R8 reset true", {lt, rt}, 2'b00, -1);
    check("R8 reset neg",  {ln, rn}, 2'b00, -1);
    check("R8 reset strobe", {ll, rl}, 2'b00, -1);
  endtask

  // Drives I2S frames and compares every bit period with the model.
  task automatic run_phase(int stop_g);
    for (int g = 0; g < stop_g; g++) begin
      int j, f, p, df, idx;
      bit vld, inw;
      logic [1:0] e_t, e_n, e_s;
      string tg_t, tg_n, tg_s;
      j = g % FB;
      f = g / FB;
      @(negedge clk);
      rst = 1'b0;
      ws  = (j >= FB/2);
      if (j >= 1 && j <= W)                  sd = lw[f][W - j];
      else if (j >= FB/2 + 1 && j <= FB/2 + W) sd = rw[f][FB/2 + W - j];
      else                                   sd = 1'($urandom);  // R2 junk
      #3;
      p   = (j == 0) ? FB - 1 : j - 1;
      df  = (j == 0) ? f - 2 : f - 1;
      vld = (df >= 1);
      inw = vld && (p >= FB - W - 1) && (p <= FB - 2);
      idx = FB - 2 - p;
      e_t = 2'b00; e_n = 2'b00;
      e_s = (vld && p == FB - 1) ? 2'b11 : 2'b00;
      if (inw) begin
        e_t = {lw[df][idx], rw[df][idx]};
        e_n = {neg_sat(lw[df])[idx], neg_sat(rw[df])[idx]};
      end
      tg_t = inw ? "R1 R2 R3 R7 R9 true" : (vld ? "R6 true idle" : "R8 true idle");
      if (inw) tg_n = (lw[df] == 16'h8000 || rw[df] == 16'h8000) ? "R5 neg" : "R4 neg";
      else     tg_n = vld ? "R6 neg idle" : "R8 neg idle";
      tg_s = vld ? "R6 strobe" : "R8 strobe";
      check(tg_t, {lt, rt}, e_t, g);
      check(tg_n, {ln, rn}, e_n, g);
      check(tg_s, {ll, rl}, e_s, g);
    end
  endtask

  initial begin
    // phase 1: directed corner words; frame 0 must never appear (R8)
    lw[0] = 16'h1234; rw[0] = 16'h4321;
    lw[1] = 16'h0001; rw[1] = 16'h8000;
    lw[2] = 16'h0000; rw[2] = 16'h7FFF;
    lw[3] = 16'hFFFF; rw[3] = 16'h0001;
    lw[4] = 16'h8000; rw[4] = 16'h8000;
    lw[5] = 16'hA5C3; rw[5] = 16'h5A3C;
    lw[6] = 16'h7FFF; rw[6] = 16'hFFFE;
    lw[7] = 16'h0100; rw[7] = 16'h8001;
    do_reset();
    run_phase(7*FB + 20);   // ends mid-frame
    // phase 2: reset mid-stream, then random words
    for (int k = 0; k < NF; k++) begin
      lw[k] = 16'($urandom);
      rw[k] = 16'($urandom);
    end
    do_reset();
    run_phase(NF*FB);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule